// File: doc/BRIEF.md
# Smooth Clock Calibration Pulse Masker

This block trims the long-term rate of a slow timebase of about 32 kHz. Every cycle of the slow clock, it reports how many enable pulses the prescaler chain downstream should count: normally one, zero when a pulse is removed, and two when a pulse is added. Across one calibration window the removed pulses follow a mask count. The added pulses follow a single increase bit. Both are spread evenly over the window, so the time error never builds up in a burst.

The full window spans 2^WIN_W slow cycles, which is 2^20 by default (32 s). Software may also pick a half window or a quarter window. With a shorter window the low bits of the mask count are dropped, so the correction per cycle stays the same. Software presents a new setting and strobes it in. The setting waits in a shadow stage and becomes active only on the first cycle of the next window. A pending flag shows that a setting is waiting. The net adjustment over a full window is 2^MASK_W times the increase bit, minus the mask count. With the default widths this gives steps of about 0.95 ppm, over a range of about −487 to +488 ppm.

Top module: `cal_pulse_masker`

## Requirements
- R1: After reset, the pending flag is 0. The active setting has no correction and selects the full window, so pulse_cnt_o is 1.
- R2: While the active setting has mask count 0 and the increase bit clear, pulse_cnt_o is 1 on every cycle.
- R3: The window is cut into blocks of 2^(WIN_W−MASK_W) cycles. The block index is the window cycle number shifted right by WIN_W−MASK_W. pulse_cnt_o is 0 exactly on block offset 0 of each block whose MASK_W-bit bit-reversed index is below the effective mask count.
- R4: With the increase bit active, pulse_cnt_o is 2 on block offset 2^(WIN_W−MASK_W−1) of every block. It is 2 on no other cycle.
- R5: Window select 00 gives a window of 2^WIN_W cycles. The sum of pulse_cnt_o over it is 2^WIN_W + 2^MASK_W·incr − mask.
- R6: Window select 01 gives a window of 2^(WIN_W−1) cycles, and mask bit 0 is ignored. The sum is the window length + 2^(MASK_W−1)·incr − (mask>>1).
- R7: Window select 10 or 11 gives a window of 2^(WIN_W−2) cycles, and mask bits 1:0 are ignored. The sum is the window length + 2^(MASK_W−2)·incr − (mask>>2).
- R8: A cycle with cal_load_i high captures win_sel_i, mask_cnt_i and incr_i, and pend_o is 1 from the next cycle. The captured setting becomes active on the first cycle of the next window, and pend_o returns to 0 at the same time. A load in the last cycle of a window stays pending until the end of the following window. In that case the setting captured earlier is the one applied at this boundary.
- R9: pulse_cnt_o only takes the values 0, 1 and 2. A removal and an addition never fall on the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow timebase clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_load_i | input | 1 | Capture strobe for a new setting |
| win_sel_i | input | 2 | Window select: 00 full, 01 half, 10/11 quarter |
| mask_cnt_i | input | MASK_W | Pulses to remove per full window |
| incr_i | input | 1 | Add 2^MASK_W pulses per full window |
| pulse_cnt_o | output | 2 | Enable pulses for this cycle (0, 1 or 2) |
| pend_o | output | 1 | A captured setting waits for the next window |

## Verification
The assertions assume only that each input is stable around the clock edge. No input has an illegal value: any value of the window select or the mask count is allowed, and cal_load_i may stay high for any number of cycles. The stimulus changes inputs on the falling edge. It loads settings both in mid-window and in the exact last cycle of a window, and it uses odd mask values so that the low bits dropped in the shorter windows are exercised. The bench uses a small WIN_W so that many windows of each length complete.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {
    WIN_FULL    = 2'b00,
    WIN_HALF    = 2'b01,
    WIN_QUARTER = 2'b10,
    WIN_QTR_ALT = 2'b11
  } win_sel_e;

  // log2 of window shortening
  function automatic logic [1:0] sel_shift(logic [1:0] sel);
    case (win_sel_e'(sel))
      WIN_FULL: return 2'd0;
      WIN_HALF: return 2'd1;
      default:  return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/cal_cfg_shadow.sv
module cal_cfg_shadow #(
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        sel_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              incr_i,
  input  logic              apply_i,
  output logic [1:0]        act_sel_o,
  output logic [MASK_W-1:0] act_mask_o,
  output logic              act_incr_o,
  output logic              pend_o
);
  logic [1:0]        sh_sel;
  logic [MASK_W-1:0] sh_mask;
  logic              sh_incr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_sel     <= '0;
      sh_mask    <= '0;
      sh_incr    <= 1'b0;
      act_sel_o  <= '0;
      act_mask_o <= '0;
      act_incr_o <= 1'b0;
      pend_o     <= 1'b0;
    end else begin
      if (load_i) begin
        sh_sel  <= sel_i;
        sh_mask <= mask_i;
        sh_incr <= incr_i;
      end
      if (apply_i && pend_o) begin
        act_sel_o  <= sh_sel;
        act_mask_o <= sh_mask;
        act_incr_o <= sh_incr;
      end
      // a load in the boundary cycle stays pending
      pend_o <= load_i | (pend_o & ~apply_i);
    end
  end
endmodule

// File: rtl/cal_win_ctr.sv
module cal_win_ctr #(
  parameter int WIN_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       shift_i,
  output logic [WIN_W-1:0] cnt_o,
  output logic             last_o
);
  logic [WIN_W-1:0] lim;

  always_comb begin
    lim    = {WIN_W{1'b1}} >> shift_i;
    last_o = (cnt_o == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (last_o) cnt_o <= '0;
    else             cnt_o <= cnt_o + WIN_W'(1);
  end
endmodule

// File: rtl/cal_pulse_gen.sv
module cal_pulse_gen #(
  parameter int WIN_W  = 20,
  parameter int MASK_W = 9
) (
  input  logic [WIN_W-1:0]  cnt_i,
  input  logic [1:0]        shift_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              incr_i,
  output logic [1:0]        pulse_cnt_o
);
  // WIN_W must exceed MASK_W; MASK_W must be at least 3
  localparam int OFF_W = WIN_W - MASK_W;
  localparam logic [OFF_W-1:0] OFF_MID = OFF_W'(1) << (OFF_W - 1);

  logic [MASK_W-1:0] blk_idx, blk_rev, mask_eff, low_clr;
  logic [OFF_W-1:0]  blk_off;
  logic              mask_hit, ins_hit;

  assign blk_idx = cnt_i[WIN_W-1:OFF_W];
  assign blk_off = cnt_i[OFF_W-1:0];

  for (genvar i = 0; i < MASK_W; i++) begin : g_rev
    assign blk_rev[i] = blk_idx[MASK_W-1-i];
  end

  always_comb begin
    low_clr     = (MASK_W'(1) << shift_i) - MASK_W'(1);
    mask_eff    = mask_i & ~low_clr;
    mask_hit    = (blk_off == '0) && (blk_rev < mask_eff);
    ins_hit     = incr_i && (blk_off == OFF_MID);
    pulse_cnt_o = mask_hit ? 2'd0 : (ins_hit ? 2'd2 : 2'd1);
  end
endmodule

// File: rtl/cal_pulse_masker.sv
module cal_pulse_masker #(
  parameter int WIN_W  = 20,
  parameter int MASK_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cal_load_i,
  input  logic [1:0]        win_sel_i,
  input  logic [MASK_W-1:0] mask_cnt_i,
  input  logic              incr_i,
  output logic [1:0]        pulse_cnt_o,
  output logic              pend_o
);
  logic [1:0]        act_sel, win_shift;
  logic [MASK_W-1:0] act_mask;
  logic              act_incr, win_last;
  logic [WIN_W-1:0]  win_cnt;

  assign win_shift = cal_pkg::sel_shift(act_sel);

  cal_cfg_shadow #(.MASK_W(MASK_W)) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cal_load_i),
    .sel_i     (win_sel_i),
    .mask_i    (mask_cnt_i),
    .incr_i    (incr_i),
    .apply_i   (win_last),
    .act_sel_o (act_sel),
    .act_mask_o(act_mask),
    .act_incr_o(act_incr),
    .pend_o    (pend_o)
  );

  cal_win_ctr #(.WIN_W(WIN_W)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(win_shift),
    .cnt_o  (win_cnt),
    .last_o (win_last)
  );

  cal_pulse_gen #(.WIN_W(WIN_W), .MASK_W(MASK_W)) i_gen (
    .cnt_i      (win_cnt),
    .shift_i    (win_shift),
    .mask_i     (act_mask),
    .incr_i     (act_incr),
    .pulse_cnt_o(pulse_cnt_o)
  );
endmodule

// File: rtl/cal_pulse_masker_chk.sv
module cal_pulse_masker_chk #(
  parameter int WIN_W  = 20,
  parameter int MASK_W = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cal_load_i,
  input logic              pend_o,
  input logic [1:0]        pulse_cnt_o,
  input logic              win_last,
  input logic [WIN_W-1:0]  win_cnt,
  input logic [MASK_W-1:0] act_mask,
  input logic              act_incr
);
  localparam int OFF_W = WIN_W - MASK_W;

  // R9
  pulse_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_cnt_o != 2'd3);

  // R8
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_load_i |=> pend_o);

  // R8
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pend_o) |-> $past(win_last));

  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_last |=> ($stable(act_mask) && $stable(act_incr)));

  // R2
  zero_corr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_mask == '0 && !act_incr) |-> pulse_cnt_o == 2'd1);

  // R3
  mask_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_cnt_o == 2'd0) |-> (win_cnt[OFF_W-1:0] == '0));

  // R4
  ins_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_cnt_o == 2'd2) |-> act_incr);

  // R5
  wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_last |=> win_cnt == '0);
endmodule

bind cal_pulse_masker cal_pulse_masker_chk #(.WIN_W(WIN_W), .MASK_W(MASK_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cal_load_i (cal_load_i),
  .pend_o     (pend_o),
  .pulse_cnt_o(pulse_cnt_o),
  .win_last   (win_last),
  .win_cnt    (win_cnt),
  .act_mask   (act_mask),
  .act_incr   (act_incr)
);

// File: tb/test_cal_pulse_masker.sv
`timescale 1ns/1ps
module test_cal_pulse_masker;
  localparam int WIN_W  = 12;
  localparam int MASK_W = 9;
  localparam int OFF_W  = WIN_W - MASK_W;
  localparam int BLK    = 1 << OFF_W;
  localparam int WDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [MASK_W-1:0] mask = '0;
  logic incr = 1'b0;
  logic [1:0] pulse;
  logic pend;

  always #2.5 clk = ~clk;

  cal_pulse_masker #(.WIN_W(WIN_W), .MASK_W(MASK_W)) i_cal_pulse_masker (
    .clk_i(clk), .rst_ni(rst_n), .cal_load_i(load), .win_sel_i(sel),
    .mask_cnt_i(mask), .incr_i(incr), .pulse_cnt_o(pulse), .pend_o(pend)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  // reference state
  int m_pos, m_wraps;
  int m_act_sel, m_act_mask, m_act_incr;
  int m_sh_sel, m_sh_mask, m_sh_incr, m_pend;
  int acc_sum, acc_mask, acc_ins;

  function automatic int kof(int s);
    return (s == 0) ? 0 : ((s == 1) ? 1 : 2);
  endfunction

  function automatic int wlen();
    return 1 << (WIN_W - kof(m_act_sel));
  endfunction

  function automatic int rev(int b);
    int r = 0;
    for (int i = 0; i < MASK_W; i++)
      if ((b >> i) & 1) r |= 1 << (MASK_W - 1 - i);
    return r;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (pos %0d)", req, act, exp, m_pos);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_wraps = 0;
      m_act_sel = 0; m_act_mask = 0; m_act_incr = 0;
      m_sh_sel = 0; m_sh_mask = 0; m_sh_incr = 0; m_pend = 0;
    end else begin
      if (m_pos == wlen() - 1) begin
        if (m_pend != 0) begin
          m_act_sel = m_sh_sel; m_act_mask = m_sh_mask; m_act_incr = m_sh_incr;
          m_pend = 0;
        end
        m_pos = 0;
        m_wraps++;
      end else begin
        m_pos++;
      end
      if (load) begin
        m_sh_sel = sel; m_sh_mask = mask; m_sh_incr = incr; m_pend = 1;
      end
    end
  end

  // per-cycle and per-window comparison
  always @(negedge clk) begin
    if (rst_n) begin
      int k, b, off, meff, exp;
      k    = kof(m_act_sel);
      b    = m_pos >> OFF_W;
      off  = m_pos & (BLK - 1);
      meff = m_act_mask & ~((1 << k) - 1);
      exp  = 1;
      if (off == 0 && rev(b) < meff) exp = 0;
      else if (m_act_incr != 0 && off == BLK / 2) exp = 2;
      if (exp == 0)      check("R3", pulse, exp);
      else if (exp == 2) check("R4", pulse, exp);
      else if (m_act_mask == 0 && m_act_incr == 0) check("R2", pulse, exp);
      else               check("R9", pulse, exp);
      check("R8", pend, m_pend);
      acc_sum += pulse;
      acc_mask += (pulse == 0);
      acc_ins += (pulse == 2);
      if (m_pos == wlen() - 1) begin
        string tag;
        tag = (k == 0) ? "R5" : ((k == 1) ? "R6" : "R7");
        check(tag, acc_sum, wlen() + ((1 << (MASK_W - k)) * m_act_incr) - (m_act_mask >> k));
        check(tag, acc_mask, m_act_mask >> k);
        check(tag, acc_ins, (1 << (MASK_W - k)) * m_act_incr);
        acc_sum = 0; acc_mask = 0; acc_ins = 0;
      end
    end else begin
      acc_sum = 0; acc_mask = 0; acc_ins = 0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG && !finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d cycles", cycles, WDOG);
      summary();
    end
  end

  task automatic load_cfg(int s, int m, int inc);
    @(negedge clk);
    load = 1'b1; sel = 2'(s); mask = MASK_W'(m); incr = inc[0];
    @(negedge clk);
    load = 1'b0; sel = 2'(~s); mask = ~mask; incr = ~incr;
  endtask

  task automatic wait_wraps(int n);
    int target = m_wraps + n;
    while (m_wraps < target) @(negedge clk);
  endtask

  task automatic run_cfg(int s, int m, int inc);
    repeat (37) @(negedge clk);
    load_cfg(s, m, inc);
    // R8: pending right after load, cleared after the boundary
    check("R8", pend, 1);
    wait_wraps(2);
    check("R8", pend, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1
    check("R1", pulse, 1);
    check("R1", pend, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", pulse, 1);
    check("R1", pend, 0);
    wait_wraps(1);                 // R2: zero correction window
    run_cfg(0, 5, 0);              // R3
    run_cfg(0, 300, 1);            // R3 R4 R5
    run_cfg(0, 511, 0);            // R5 extreme negative
    run_cfg(0, 0, 1);              // R4 extreme positive
    run_cfg(1, 301, 1);            // R6 bit0 ignored
    run_cfg(2, 303, 0);            // R7
    run_cfg(3, 7, 1);              // R7 alternate select
    // R8: load A mid-window, then B in the last cycle of the window
    load_cfg(0, 100, 0);
    @(negedge clk);
    while (m_pos != wlen() - 1) @(negedge clk);
    load = 1'b1; sel = 2'b01; mask = MASK_W'(77); incr = 1'b1;
    @(negedge clk);
    load = 1'b0;
    check("R8", pend, 1);
    check("R8", m_act_mask, 100);
    wait_wraps(2);
    check("R8", pend, 0);
    run_cfg(0, 0, 0);              // R2 back to zero
    finished = 1;
    summary();
  end
endmodule